// File: doc/BRIEF.md
# Configurable GPIO Pad Mode Controller

This block controls an eight-pin general-purpose I/O port. Software programs it through a small synchronous register bus. For each pin it stores a direction bit, an output data bit and two mode bits. It turns these into five pad control lines per pin: P-side drive enable, N-side drive enable, output enable, pull-up enable and pull-down enable. When a pin is an output, its two mode bits choose one of four drive styles: released, P-only open drain, N-only open drain, or full push-pull. When a pin is an input, the same two mode bits choose no pull, a pull-down or a pull-up.

The pad input levels pass through a two-stage synchronizer into a read-only register, so software can read back the pin states. The pad itself sits outside the block. The P-side enable drives the pad high, the N-side enable drives it low, and the pulls are weak resistors.

The bus window holds five byte registers starting at byte offset 0x250:

| Offset | Register | Access |
|--------|----------|--------|
| 0x250 | Output data | read/write |
| 0x251 | Direction | read/write |
| 0x252 | Mode bit 0 | read/write |
| 0x253 | Mode bit 1 | read/write |
| 0x254 | Synchronized input | read-only |

In every register, bit n belongs to pin n.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every register reads 0x00 and every pad control output is 0. With all registers at zero, each pin is a released output.
- R2: For a pin with direction 0 (output) and mode bits {bit1,bit0} = 11 (push-pull), the P enable equals the data bit, the N enable equals the inverted data bit, and the output enable is 1. P and N are never both enabled on any pin.
- R3: For an output pin with mode 01 (P-only open drain), the P enable and the output enable equal the data bit, and the N enable is 0.
- R4: For an output pin with mode 10 (N-only open drain), the N enable and the output enable equal the inverted data bit, and the P enable is 0.
- R5: For an output pin with mode 00, the P enable, N enable and output enable are all 0.
- R6: For a pin with direction 1 (input), all three drive lines are 0. Mode 01 enables only the pull-down, mode 10 enables only the pull-up, and modes 00 and 11 enable neither pull.
- R7: No pin ever has its pull-up and pull-down enabled together, and no output pin has either pull enabled.
- R8: A byte access (size 0) uses bus data bits 7:0. It writes and reads offsets 0x250 (output data), 0x251 (direction), 0x252 (mode bit 0) and 0x253 (mode bit 1), with bit n of each register belonging to pin n.
- R9: A halfword access (size 1) at an even offset reaches two registers: the byte at the offset takes bus bits 7:0 and the next byte takes bus bits 15:8. So a halfword at 0x252 writes both mode registers, and a halfword at 0x250 writes the data and direction registers. A halfword write at an odd offset changes nothing.
- R10: Offset 0x254 reads the pad input levels after a two-flop synchronizer. A change on the pad input shows up after the second rising clock edge, not after the first. Writes to 0x254 have no effect.
- R11: A write outside offsets 0x250 to 0x254 changes no register, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_size | input | 1 | 0 = byte access, 1 = halfword access |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 16 | Write data; bits 7:0 go to the addressed byte |
| bus_rdata | output | 16 | Combinational read data for the current address and size |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_p_en | output | 8 | Per-pin P-side drive (pull high) enable |
| pad_n_en | output | 8 | Per-pin N-side drive (pull low) enable |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_pd | output | 8 | Per-pin pull-down enable |

## Verification
The bound checker checks these properties on every cycle:
- the P and N enables are never both on for a pin;
- the pull-up and pull-down are never both on for a pin;
- output pins have no pulls, and input pins have no drivers;
- a released or P-only pin never has its N enable on;
- the input register trails the pad pins by exactly two cycles;
- a halfword write at an odd offset leaves every register unchanged.

Only the directed scenarios show the following:
- the drive and pull line values for each mode under both data polarities;
- which byte lane lands in which register on byte and halfword writes;
- the reset values as seen through the bus;
- that writes outside the map, or to the input register, are dropped.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_PSRC = 2'b01,
    MODE_NSNK = 2'b10,
    MODE_PP   = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic p_en;
    logic n_en;
    logic oe;
    logic pu;
    logic pd;
  } pad_ctl_t;

  localparam int REG_DOUT  = 0;
  localparam int REG_DIR   = 1;
  localparam int REG_MODE0 = 2;
  localparam int REG_MODE1 = 3;
  localparam int REG_IN    = 4;
  localparam int NUM_REGS  = 5;
  localparam int NUM_RW    = 4;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode
  import gpio_pad_pkg::*;
(
  input  logic     dir_in,
  input  logic     mode0,
  input  logic     mode1,
  input  logic     dout,
  output pad_ctl_t ctl
);

  pin_mode_e mode;

  assign mode = pin_mode_e'({mode1, mode0});

  always_comb begin
    ctl = '0;
    if (!dir_in) begin
      unique case (mode)
        MODE_OFF: begin
          ctl.p_en = 1'b0;
          ctl.n_en = 1'b0;
        end
        MODE_PSRC: ctl.p_en = dout;
        MODE_NSNK: ctl.n_en = ~dout;
        MODE_PP: begin
          ctl.p_en = dout;
          ctl.n_en = ~dout;
        end
        default: ctl = '0;
      endcase
      ctl.oe = ctl.p_en | ctl.n_en;
    end else begin
      ctl.pu = (mode == MODE_NSNK);
      ctl.pd = (mode == MODE_PSRC);
    end
  end

endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_pad_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [NPIN-1:0]   in_levels,
  output logic [15:0]       bus_rdata,
  output logic [NPIN-1:0]   dout_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   mode0_q,
  output logic [NPIN-1:0]   mode1_q
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [ADDR_W-1:0] off;
  logic              in_map;
  logic [2:0]        lo_idx;
  logic [2:0]        hi_idx;
  logic              byte_wr;
  logic              half_wr;
  logic [NPIN-1:0]   rf_q [NUM_RW];
  logic [NPIN-1:0]   rf_n [NUM_RW];
  logic [7:0]        rbyte [8];

  assign off     = bus_addr - BASE_A;
  assign in_map  = (off < ADDR_W'(NUM_REGS));
  assign lo_idx  = off[2:0];
  assign hi_idx  = lo_idx + 3'd1;
  assign byte_wr = bus_wr & in_map & ~bus_size;
  assign half_wr = bus_wr & in_map & bus_size & ~off[0];

  // next-state: byte lane 0 to addressed register, lane 1 to the next one
  always_comb begin
    for (int r = 0; r < NUM_RW; r++) begin
      rf_n[r] = rf_q[r];
      if ((byte_wr || half_wr) && (lo_idx == 3'(r)))
        rf_n[r] = bus_wdata[NPIN-1:0];
      else if (half_wr && (hi_idx == 3'(r)))
        rf_n[r] = bus_wdata[8 +: NPIN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_RW; r++) rf_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_RW; r++) rf_q[r] <= rf_n[r];
    end
  end

  // read path
  always_comb begin
    for (int i = 0; i < 8; i++) rbyte[i] = 8'h00;
    for (int r = 0; r < NUM_RW; r++) rbyte[r][NPIN-1:0] = rf_q[r];
    rbyte[REG_IN][NPIN-1:0] = in_levels;
    bus_rdata = 16'h0000;
    if (in_map) begin
      if (!bus_size)
        bus_rdata = {8'h00, rbyte[lo_idx]};
      else if (!off[0])
        bus_rdata = {rbyte[hi_idx], rbyte[lo_idx]};
    end
  end

  assign dout_q  = rf_q[REG_DOUT];
  assign dir_q   = rf_q[REG_DIR];
  assign mode0_q = rf_q[REG_MODE0];
  assign mode1_q = rf_q[REG_MODE1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_p_en,
  output logic [NPIN-1:0]   pad_n_en,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_pd
);

  logic [1:0]      rst_sync_q;
  logic            rst_n_s;
  logic [NPIN-1:0] dout_q;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] mode0_q;
  logic [NPIN-1:0] mode1_q;
  logic [NPIN-1:0] in_sync;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  gpio_pad_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .in_levels (in_sync),
    .bus_rdata (bus_rdata),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .mode0_q   (mode0_q),
    .mode1_q   (mode1_q)
  );

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    pad_ctl_t ctl;
    gpio_pin_mode u_mode (
      .dir_in (dir_q[g]),
      .mode0  (mode0_q[g]),
      .mode1  (mode1_q[g]),
      .dout   (dout_q[g]),
      .ctl    (ctl)
    );
    assign pad_p_en[g] = ctl.p_en;
    assign pad_n_en[g] = ctl.n_en;
    assign pad_oe[g]   = ctl.oe;
    assign pad_pu[g]   = ctl.pu;
    assign pad_pd[g]   = ctl.pd;
  end

endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   pad_in,
  input logic [NPIN-1:0]   dir,
  input logic [NPIN-1:0]   mode0,
  input logic [NPIN-1:0]   mode1,
  input logic [NPIN-1:0]   dout,
  input logic [NPIN-1:0]   in_sync,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_p_en,
  input logic [NPIN-1:0]   pad_n_en,
  input logic [NPIN-1:0]   pad_pu,
  input logic [NPIN-1:0]   pad_pd
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= 2'd0;
    else if (age_q != 2'd2)   age_q <= age_q + 2'd1;
  end

  // R2
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_p_en & pad_n_en) == '0);

  // R7
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R7
  out_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu | pad_pd) & ~dir) == '0);

  // R6
  in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_p_en | pad_n_en | pad_oe) & dir) == '0);

  // R5
  off_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~mode0 & ~mode1) == '0);

  // R3
  psrc_no_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_n_en & mode0 & ~mode1) == '0);

  // R10
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (in_sync == $past(pad_in, 2)));

  // R9
  odd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size && bus_addr[0]) |=>
      ($stable(dir) && $stable(mode0) && $stable(mode1) && $stable(dout)));

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .bus_wr   (bus_wr),
  .bus_size (bus_size),
  .bus_addr (bus_addr),
  .pad_in   (pad_in),
  .dir      (dir_q),
  .mode0    (mode0_q),
  .mode1    (mode1_q),
  .dout     (dout_q),
  .in_sync  (in_sync),
  .pad_oe   (pad_oe),
  .pad_p_en (pad_p_en),
  .pad_n_en (pad_n_en),
  .pad_pu   (pad_pu),
  .pad_pd   (pad_pd)
);

// File: tb/gpio_pad_ctrl_test.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_size;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  pad_in;
  logic [7:0]  pad_oe, pad_p_en, pad_n_en, pad_pu, pad_pd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gpio_pad_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_p_en(pad_p_en),
    .pad_n_en(pad_n_en), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic sz, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic sz, output logic [15:0] d);
    bus_addr = a; bus_size = sz; bus_wr = 1'b0;
    #0.5;
    d = bus_rdata;
  endtask

  // per-pin expectation taken from the requirement tables
  task automatic model(input logic [7:0] dir, c0, c1, d,
                       output logic [7:0] p, n, oe, pu, pd);
    for (int i = 0; i < 8; i++) begin
      p[i] = 0; n[i] = 0; pu[i] = 0; pd[i] = 0;
      if (!dir[i]) begin
        if (c0[i]) p[i] = d[i];
        if (c1[i]) n[i] = ~d[i];
      end else begin
        pu[i] = c1[i] & ~c0[i];
        pd[i] = c0[i] & ~c1[i];
      end
      oe[i] = p[i] | n[i];
    end
  endtask

  task automatic check_pads(input string tag, input logic [7:0] mask,
                            input logic [7:0] dir, c0, c1, d);
    logic [7:0] p, n, oe, pu, pd;
    model(dir, c0, c1, d, p, n, oe, pu, pd);
    chk({tag, " p_en"}, 16'(pad_p_en & mask), 16'(p & mask));
    chk({tag, " n_en"}, 16'(pad_n_en & mask), 16'(n & mask));
    chk({tag, " oe"},   16'(pad_oe & mask),   16'(oe & mask));
    chk({tag, " pu"},   16'(pad_pu & mask),   16'(pu & mask));
    chk({tag, " pd"},   16'(pad_pd & mask),   16'(pd & mask));
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 'h250; a <= 'h254; a++) begin
      rd(12'(a), 1'b0, v);
      chk("R1 reg reset", v, 16'h0000);
    end
    chk("R1 pads reset", 16'({pad_p_en, pad_n_en} | {pad_oe, pad_pu} | 16'(pad_pd)), 16'h0000);
  endtask

  task automatic t_bytes;
    logic [15:0] v;
    wr(12'h250, 1'b0, 16'hFFA5);
    wr(12'h251, 1'b0, 16'h003C);
    wr(12'h252, 1'b0, 16'h11F0);
    wr(12'h253, 1'b0, 16'h00CC);
    rd(12'h250, 1'b0, v); chk("R8 data byte", v, 16'h00A5);
    rd(12'h251, 1'b0, v); chk("R8 dir byte", v, 16'h003C);
    rd(12'h252, 1'b0, v); chk("R8 mode0 byte", v, 16'h00F0);
    rd(12'h253, 1'b0, v); chk("R8 mode1 byte", v, 16'h00CC);
  endtask

  task automatic t_out_modes;
    // pins 0/4 mode 00, 1/5 mode 01, 2/6 mode 10, 3/7 mode 11
    wr(12'h251, 1'b0, 16'h0000);
    wr(12'h252, 1'b0, 16'h00AA);
    wr(12'h253, 1'b0, 16'h00CC);
    foreach (bit_pat[k]) ;
    for (int k = 0; k < 2; k++) begin
      logic [7:0] d;
      d = k ? 8'hF0 : 8'h0F;
      wr(12'h250, 1'b0, 16'(d));
      check_pads("R5 off", 8'h11, 8'h00, 8'hAA, 8'hCC, d);
      check_pads("R3 psrc", 8'h22, 8'h00, 8'hAA, 8'hCC, d);
      check_pads("R4 nsnk", 8'h44, 8'h00, 8'hAA, 8'hCC, d);
      check_pads("R2 pp", 8'h88, 8'h00, 8'hAA, 8'hCC, d);
      chk("R7 no pulls on outputs", 16'(pad_pu | pad_pd), 16'h0000);
    end
  endtask
  logic [1:0] bit_pat;

  task automatic t_in_modes;
    wr(12'h250, 1'b0, 16'h00FF);
    wr(12'h251, 1'b0, 16'h00FF);
    check_pads("R6 input", 8'hFF, 8'hFF, 8'hAA, 8'hCC, 8'hFF);
    chk("R7 pulls exclusive", 16'(pad_pu & pad_pd), 16'h0000);
    // mixed directions: upper nibble input, lower nibble output
    wr(12'h251, 1'b0, 16'h00F0);
    check_pads("R6 mixed", 8'hFF, 8'hF0, 8'hAA, 8'hCC, 8'hFF);
  endtask

  task automatic t_half;
    logic [15:0] v;
    wr(12'h252, 1'b1, 16'h1234);
    rd(12'h252, 1'b0, v); chk("R9 half lo to mode0", v, 16'h0034);
    rd(12'h253, 1'b0, v); chk("R9 half hi to mode1", v, 16'h0012);
    rd(12'h252, 1'b1, v); chk("R9 half read", v, 16'h1234);
    wr(12'h250, 1'b1, 16'hABCD);
    rd(12'h250, 1'b1, v); chk("R9 half data/dir", v, 16'hABCD);
    wr(12'h251, 1'b1, 16'hFFFF);
    rd(12'h250, 1'b1, v); chk("R9 odd half ignored lo", v, 16'hABCD);
    rd(12'h252, 1'b1, v); chk("R9 odd half ignored hi", v, 16'h1234);
  endtask

  task automatic t_input;
    logic [15:0] v;
    @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk);
    rd(12'h254, 1'b0, v); chk("R10 after one edge", v, 16'h0000);
    @(negedge clk);
    rd(12'h254, 1'b0, v); chk("R10 after two edges", v, 16'h005A);
    wr(12'h254, 1'b0, 16'h00FF);
    rd(12'h254, 1'b0, v); chk("R10 write ignored", v, 16'h005A);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    wr(12'h260, 1'b0, 16'h00FF);
    wr(12'h24F, 1'b1, 16'hFFFF);
    rd(12'h260, 1'b0, v); chk("R11 read unmapped", v, 16'h0000);
    rd(12'h24F, 1'b0, v); chk("R11 read below base", v, 16'h0000);
    rd(12'h250, 1'b1, v); chk("R11 data/dir unchanged", v, 16'hABCD);
    rd(12'h252, 1'b1, v); chk("R11 modes unchanged", v, 16'h1234);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_size = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bytes();
    t_out_modes();
    t_in_modes();
    t_half();
    t_input();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule